// File: doc/BRIEF.md
# Banked Shared Scratchpad Arbiter

This block is an on-chip scratchpad shared by a group of sixteen lanes. The storage is split into sixteen independent banks of 32-bit words, and each bank can serve one word per clock. A request covers the whole lane group at once. It carries a per-lane active mask, a word address and write data for every lane, and a single read/write flag.

The low four bits of a word address pick its bank. When several active lanes need different words of the same bank, the block serves the request in several passes. In each pass it lets at most one distinct word per bank through and masks out every lane that must wait. Lanes that want the same word share one pass as a broadcast. When the last lane has been served, the block pulses a done flag and presents the read data of every lane. A new request is taken only while the block is idle, and this is shown on a ready output.

Top module: `bank_scratch`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is all zeros.
- R2: The storage holds 16 banks of 256 words of 32 bits each. The bank of word address A is A[3:0] and the row is A[11:4]. Active lanes that all address different banks are served in a single pass.
- R3: The number of passes P is the largest number of distinct word addresses that active lanes place in any single bank, with a minimum of 1. `rsp_done` is high exactly P clock cycles after the edge that accepted the request.
- R4: Active lanes that address the same word are served in the same pass, so a broadcast read of one word by every lane takes one pass.
- R5: A write request stores each active lane's data at its address. A later read of that address returns it.
- R6: If two or more active lanes of one write request address the same word, the word ends up holding the data of the highest-numbered of those lanes.
- R7: An inactive lane writes nothing, and its entry in `rsp_rdata` is 0. Every entry of `rsp_rdata` is 0 after a write request.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle in which `rsp_done` is 1. A request presented while `req_ready` is 0 is ignored and changes no stored word.
- R9: `rsp_done` is a single-cycle pulse that occurs only while `req_ready` is 1. `rsp_rdata` holds the same value from that pulse until the next request is accepted.
- R10: No request keeps the block busy for more than 16 passes, the number of lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_active | input | 16 | Per-lane active mask |
| req_addr | input | 16x12 | Per-lane word address, lane i in bits [12i+11:12i] |
| req_wdata | input | 16x32 | Per-lane write data |
| rsp_done | output | 1 | One-cycle pulse when every lane has been served |
| rsp_rdata | output | 16x32 | Per-lane read data, valid from the done pulse |

## Verification
Requests are run in several patterns:
- A stride of one word puts every lane in its own bank. This isolates the bank mapping and should always finish in a single pass.
- A stride of sixteen words puts every lane in one bank and forces the worst case of sixteen passes.
- A half-and-half split over two words of one bank, and an all-lanes broadcast, separate a true conflict from shared-word merging. The first needs two passes and the second needs one.
- A same-word write storm checks which lane wins. Partial masks show that inactive lanes neither write nor return data.
- Pseudo-random requests over a small address window mix conflicts, broadcasts and masks. The pass count and data are predicted from a reference memory in the bench.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int LANES      = 16;
    localparam int BANKS      = 16;
    localparam int BANK_WORDS = 256;
    localparam int DW         = 32;

    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ROW_BITS  = $clog2(BANK_WORDS);
    localparam int AW        = BANK_BITS + ROW_BITS;
    localparam int LANE_BITS = $clog2(LANES);

    typedef logic [LANES-1:0]         lane_mask_t;
    typedef logic [AW-1:0]            waddr_t;
    typedef logic [DW-1:0]            word_t;
    typedef logic [BANK_BITS-1:0]     bank_t;
    typedef logic [ROW_BITS-1:0]      row_t;
    typedef logic [LANES-1:0][AW-1:0] addr_vec_t;
    typedef logic [LANES-1:0][DW-1:0] data_vec_t;

    typedef enum logic {
        SP_IDLE  = 1'b0,
        SP_SERVE = 1'b1
    } sp_state_e;

    typedef struct packed {
        logic      we;
        addr_vec_t addr;
        data_vec_t wdata;
    } sp_req_t;

    function automatic bank_t bank_of(input waddr_t a);
        return a[BANK_BITS-1:0];
    endfunction

    function automatic row_t row_of(input waddr_t a);
        return a[AW-1:BANK_BITS];
    endfunction
endpackage

// File: rtl/bsp_pass_sel.sv
module bsp_pass_sel
    import bsp_pkg::*;
(
    input  lane_mask_t pend,
    input  addr_vec_t  addr,
    output lane_mask_t serve
);
    // For every lane, find the lowest pending lane in the same bank;
    // the lane is served when it wants the same word as that leader.
    logic [LANES-1:0][LANE_BITS-1:0] lead;
    logic [LANES-1:0]                found;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lead[i]  = LANE_BITS'(i);
            found[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                if (!found[i] && pend[j] && (bank_of(addr[j]) == bank_of(addr[i]))) begin
                    lead[i]  = LANE_BITS'(j);
                    found[i] = 1'b1;
                end
            end
            serve[i] = pend[i] && (addr[lead[i]] == addr[i]);
        end
    end
endmodule

// File: rtl/bsp_bank_port.sv
module bsp_bank_port
    import bsp_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  lane_mask_t serve,
    input  addr_vec_t  addr,
    input  data_vec_t  wdata,
    input  logic       we,
    output logic       wr,
    output row_t       row,
    output word_t      wd
);
    logic hit;

    // All served lanes of one bank share one word; the highest lane's data wins.
    always_comb begin
        hit = 1'b0;
        row = '0;
        wd  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (serve[i] && (bank_of(addr[i]) == BANK_BITS'(BANK_ID))) begin
                if (!hit) row = row_of(addr[i]);
                hit = 1'b1;
                wd  = wdata[i];
            end
        end
        wr = hit && we;
    end
endmodule

// File: rtl/bsp_bank.sv
module bsp_bank
    import bsp_pkg::*;
(
    input  logic  clk,
    input  logic  wr,
    input  row_t  row,
    input  word_t wd,
    output word_t rd
);
    word_t mem [BANK_WORDS];

    always_ff @(posedge clk) begin
        if (wr) mem[row] <= wd;
    end

    assign rd = mem[row];
endmodule

// File: rtl/bank_scratch.sv
module bank_scratch
    import bsp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_we,
    input  logic [LANES-1:0]          req_active,
    input  logic [LANES-1:0][AW-1:0]  req_addr,
    input  logic [LANES-1:0][DW-1:0]  req_wdata,
    output logic                      rsp_done,
    output logic [LANES-1:0][DW-1:0]  rsp_rdata
);
    sp_state_e  st;
    lane_mask_t pend;
    sp_req_t    req_q;
    data_vec_t  rdata_q;
    logic       done_q;

    lane_mask_t serve;
    lane_mask_t remain;
    logic       bank_we;

    logic  [BANKS-1:0] b_wr;
    row_t  b_row [BANKS];
    word_t b_wd  [BANKS];
    word_t b_rd  [BANKS];

    bsp_pass_sel i_sel (
        .pend  (pend),
        .addr  (req_q.addr),
        .serve (serve)
    );

    assign remain  = pend & ~serve;
    assign bank_we = req_q.we && (st == SP_SERVE);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bsp_bank_port #(.BANK_ID(b)) i_port (
            .serve (serve),
            .addr  (req_q.addr),
            .wdata (req_q.wdata),
            .we    (bank_we),
            .wr    (b_wr[b]),
            .row   (b_row[b]),
            .wd    (b_wd[b])
        );
        bsp_bank i_mem (
            .clk (clk),
            .wr  (b_wr[b]),
            .row (b_row[b]),
            .wd  (b_wd[b]),
            .rd  (b_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SP_IDLE;
            pend    <= '0;
            req_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SP_IDLE: begin
                    if (req_valid) begin
                        st          <= SP_SERVE;
                        pend        <= req_active;
                        req_q.we    <= req_we;
                        req_q.addr  <= req_addr;
                        req_q.wdata <= req_wdata;
                        rdata_q     <= '0;
                    end
                end
                SP_SERVE: begin
                    pend <= remain;
                    for (int i = 0; i < LANES; i++) begin
                        if (serve[i] && !req_q.we)
                            rdata_q[i] <= b_rd[bank_of(req_q.addr[i])];
                    end
                    if (remain == '0) begin
                        st     <= SP_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= SP_IDLE;
            endcase
        end
    end

    assign req_ready = (st == SP_IDLE);
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/bank_scratch_chk.sv
module bank_scratch_chk
    import bsp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done
);
    localparam int CW = $clog2(LANES + 2) + 1;
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || req_ready) busy_cnt <= '0;
        else                  busy_cnt <= busy_cnt + 1'b1;
    end

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_returns_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> rsp_done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (req_ready && $past(!req_ready)));

    p_pass_bound_r10: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= CW'(LANES));
endmodule

bind bank_scratch bank_scratch_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done)
);

// File: tb/test_bank_scratch.sv
`timescale 1ns/1ps
module test_bank_scratch;
    import bsp_pkg::*;

    logic      clk = 1'b0;
    logic      rst = 1'b1;
    logic      req_valid = 1'b0;
    logic      req_ready;
    logic      req_we = 1'b0;
    lane_mask_t req_active = '0;
    addr_vec_t req_addr = '0;
    data_vec_t req_wdata = '0;
    logic      rsp_done;
    data_vec_t rsp_rdata;

    always #2.5 clk = ~clk;

    bank_scratch i_bank_scratch (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_active(req_active), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        int        lat;
        int        acc;
        data_vec_t rd;
        string     tag;
    } item_t;

    item_t     sb[$];
    word_t     ref_mem [BANKS*BANK_WORDS];
    int        cyc = 0;
    int        n_run = 0;
    int        n_fail = 0;
    data_vec_t last_exp = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string msg);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Driver: predicts passes and data, waits for ready, issues, queues the item.
    task automatic send(input logic we, input lane_mask_t act, input addr_vec_t a,
                        input data_vec_t d, input string tag);
        item_t it;
        int    worst;
        worst = 1;
        for (int b = 0; b < BANKS; b++) begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < LANES; i++) begin
                bit dup;
                dup = 0;
                if (act[i] && int'(a[i][BANK_BITS-1:0]) == b) begin
                    for (int j = 0; j < i; j++)
                        if (act[j] && a[j] == a[i]) dup = 1;
                    if (!dup) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        it.lat = worst;
        it.tag = tag;
        it.rd  = '0;
        for (int i = 0; i < LANES; i++)
            if (!we && act[i]) it.rd[i] = ref_mem[a[i]];
        if (we)
            for (int i = 0; i < LANES; i++)
                if (act[i]) ref_mem[a[i]] = d[i];
        while (!req_ready) @(negedge clk);
        req_we = we; req_active = act; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        it.acc = cyc;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", $sformatf("ready after accept act=%0b exp=0 (%s)", req_ready, tag));
    endtask

    // Monitor: pops the scoreboard on every done pulse.
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "done with empty scoreboard act=1 exp=0");
            end else begin
                item_t it;
                it = sb.pop_front();
                check(cyc - it.acc == it.lat, "R3",
                      $sformatf("%s passes act=%0d exp=%0d", it.tag, cyc - it.acc, it.lat));
                check(rsp_rdata == it.rd, "R5",
                      $sformatf("%s rdata act=%h exp=%h", it.tag, rsp_rdata, it.rd));
                last_exp = it.rd;
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0 || !req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        addr_vec_t a;
        data_vec_t d;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_rdata == '0, "R1",
              $sformatf("reset ready=%0b done=%0b rdata=%h exp 1/0/0", req_ready, rsp_done, rsp_rdata));
        rst = 1'b0;

        // R2 R5: fill all of memory, one row per request, every lane in its own bank
        for (int r = 0; r < BANK_WORDS; r++) begin
            for (int i = 0; i < LANES; i++) begin
                a[i] = AW'(r * BANKS + i);
                d[i] = 32'hA500_0000 ^ (r << 8) ^ i;
            end
            send(1'b1, '1, a, d, "R2 fill");
        end
        drain();

        // R2: read back a stride-one row, single pass
        for (int i = 0; i < LANES; i++) a[i] = AW'(5 * BANKS + i);
        send(1'b0, '1, a, '0, "R2 stride1 read");

        // R3: all lanes in bank 0 on different rows, 16 passes
        for (int i = 0; i < LANES; i++) begin
            a[i] = AW'(i * BANKS);
            d[i] = 32'hC0DE_0000 + i;
        end
        send(1'b1, '1, a, d, "R3 stride16 write");
        send(1'b0, '1, a, '0, "R3 stride16 read");

        // R4: broadcast read of one word
        for (int i = 0; i < LANES; i++) a[i] = AW'(5);
        send(1'b0, '1, a, '0, "R4 broadcast");
        drain();
        // R9: read data held after done while idle
        repeat (3) @(negedge clk);
        check(rsp_rdata == last_exp, "R9", $sformatf("held rdata act=%h exp=%h", rsp_rdata, last_exp));

        // R3 R4: two words in bank 3, 2 passes
        for (int i = 0; i < LANES; i++) a[i] = (i < 8) ? AW'(3) : AW'(19);
        send(1'b0, '1, a, '0, "R4 two-word split");

        // R6: all lanes write one word, highest lane wins
        for (int i = 0; i < LANES; i++) begin
            a[i] = AW'(40);
            d[i] = 32'h6600_0000 + i;
        end
        send(1'b1, '1, a, d, "R6 write storm");
        send(1'b0, 16'h0001, a, '0, "R6 winner read");
        drain();
        check(rsp_rdata[0] == 32'h6600_000F, "R6", $sformatf("winner act=%h exp=6600000f", rsp_rdata[0]));

        // R7: partial write mask, then full read shows inactive lanes untouched
        for (int i = 0; i < LANES; i++) begin
            a[i] = AW'(9 * BANKS + i);
            d[i] = 32'h7700_0000 + i;
        end
        send(1'b1, 16'h00F0, a, d, "R7 masked write");
        send(1'b0, '1, a, '0, "R7 readback");
        send(1'b0, 16'h0F0F, a, '0, "R7 masked read");
        drain();
        check(rsp_rdata[4] == '0 && rsp_rdata[0] != '0, "R7",
              $sformatf("masked lanes act=%h/%h exp=0/nonzero", rsp_rdata[4], rsp_rdata[0]));

        // R3: nothing active still completes in one pass
        send(1'b0, '0, a, '0, "R3 empty");

        // R8: request while busy is ignored
        for (int i = 0; i < LANES; i++) a[i] = AW'(i * BANKS + 1);
        send(1'b0, '1, a, '0, "R8 long read");
        req_we = 1'b1; req_active = '1; req_wdata = '1;
        for (int i = 0; i < LANES; i++) req_addr[i] = AW'(7);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        drain();
        for (int i = 0; i < LANES; i++) a[i] = AW'(7);
        send(1'b0, '1, a, '0, "R8 ignored write");

        // Mixed pseudo-random traffic in a small window
        for (int k = 0; k < 60; k++) begin
            lane_mask_t act;
            logic       we;
            act = LANES'(rnd());
            we  = rnd() % 3 == 0;
            for (int i = 0; i < LANES; i++) begin
                a[i] = AW'(rnd() % 64);
                d[i] = rnd();
            end
            send(we, act, a, d, "R3 random");
        end
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule